// File: doc/BRIEF.md
# Pin I/O Controller with Per-Pin Event Detection

This block manages 32 general-purpose pins through a 16-bit register bus. Each pin can be an input or a driven output. Every pin also carries its own event detector, which senses either an edge or a level of a chosen polarity. The detector can latch what it sees until software acknowledges it, or it can pass the live condition straight to the status bit. A registered request line is raised whenever any enabled pin has a status bit set.

Every 32-bit control word is reached as two 16-bit halves. The lower half sits at the even word address and the upper half at the next word. Pin inputs are resynchronised before any use. Besides the pin drive, the block exports a per-pin pull request (use and up/down selection) for the pad ring, and a second 32-bit output word for general control use.

Top module: `gpio_ctl`

## Requirements
- R1: Each pin has a direction bit (1 = output, 0 = input). A pin whose direction bit is 1 and whose pull-use bit is 0 has `pin_oe` high and drives `pin_out` from the drive register, which is written at byte offsets 0x04/0x06. Direction sits at 0x00/0x02.
- R2: A read of 0x04/0x06 returns the drive value on output pins and the synchronised input on input pins. A change on `pin_in` becomes visible to a read after two rising clock edges.
- R3: Each 32-bit register occupies two 16-bit words: bits 15:0 at the even offset and bits 31:16 at offset+2. Writing one half leaves the other half unchanged. The offsets are: status 0x08, enable 0x0C, trigger type 0x10, polarity 0x14, hold 0x18, second output word 0x1C, pull-use 0x20, pull-direction 0x24.
- R4: With the trigger bit at 1 (edge), the polarity bit selects the edge that is detected: 1 detects a rising edge and 0 detects a falling edge of the synchronised input.
- R5: With the trigger bit at 0 (level), the condition is true while the synchronised input equals the polarity bit (1 = active high, 0 = active low).
- R6: With the hold bit at 1, a detected event stays set in the status register. Writing 1 to a status bit clears it and writing 0 leaves it unchanged. A condition that is still present when the clear is written wins, and the bit stays set.
- R7: With the hold bit at 0, the status bit follows the live condition. An edge therefore shows as a status pulse one cycle long.
- R8: Clearing an enable bit removes that pin from `irq` and leaves its status bit untouched.
- R9: `irq` is a register that holds the OR, over all pins, of status AND enable. It rises one clock after the status bit does.
- R10: `pull_en` and `pull_up` reflect the pull-use and pull-direction registers. A pin with pull-use set is never driven, even if its direction bit is 1.
- R11: The second output word (0x1C/0x1E) appears on `aux_out` and reads back unchanged.
- R12: Reset is synchronous and active high. It zeroes all registers, so every pin is an input, no pull is requested, all enables are off and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address of a 16-bit register word |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_in | input | 32 | Raw pin levels from the pads |
| pin_out | output | 32 | Drive values for the pins |
| pin_oe | output | 32 | Output enable for each pin |
| pull_en | output | 32 | Pull request for each pin |
| pull_up | output | 32 | Pull direction (1 = up, 0 = down) |
| aux_out | output | 32 | Second output word |
| irq | output | 1 | Combined interrupt request, registered |

## Verification
The hardest case to reach is the pass-through edge event. Its status bit is high for a single cycle, so an ordinary register read after a settle delay never sees it. The bench therefore parks the bus address on the status word before it toggles the pin. It then samples the read data on the falling edge after exactly the third rising edge, and again one cycle later. The second sample confirms that the bit has dropped and that `irq` has followed one cycle behind. A hold-mode clear that is written while a level condition is still present is the second delicate case: the bench raises the pin first, then writes the clear, and expects the bit to stay set.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    parameter int GPIO_PINS = 32;
    parameter int BUS_W     = 16;
    localparam int HI_W     = GPIO_PINS - BUS_W;

    // word index = byte address bits [5:2]; bit 1 picks the upper half
    typedef enum logic [3:0] {
        RID_DIR  = 4'd0,
        RID_PIN  = 4'd1,
        RID_STAT = 4'd2,
        RID_EN   = 4'd3,
        RID_TRIG = 4'd4,
        RID_POL  = 4'd5,
        RID_HOLD = 4'd6,
        RID_AUX  = 4'd7,
        RID_PUSE = 4'd8,
        RID_PDIR = 4'd9
    } reg_id_e;

    typedef struct packed {
        logic [GPIO_PINS-1:0] dir;
        logic [GPIO_PINS-1:0] drv;
        logic [GPIO_PINS-1:0] en;
        logic [GPIO_PINS-1:0] trig;
        logic [GPIO_PINS-1:0] pol;
        logic [GPIO_PINS-1:0] hold;
        logic [GPIO_PINS-1:0] aux;
        logic [GPIO_PINS-1:0] puse;
        logic [GPIO_PINS-1:0] pdir;
    } pin_cfg_t;

    function automatic logic [GPIO_PINS-1:0] put_half(
        input logic [GPIO_PINS-1:0] old,
        input logic [BUS_W-1:0]     wd,
        input logic                 hi
    );
        logic [GPIO_PINS-1:0] r;
        r = old;
        if (hi) r[GPIO_PINS-1:BUS_W] = wd[HI_W-1:0];
        else    r[BUS_W-1:0]         = wd;
        return r;
    endfunction

    function automatic logic [BUS_W-1:0] get_half(
        input logic [GPIO_PINS-1:0] v,
        input logic                 hi
    );
        logic [BUS_W-1:0] r;
        r = '0;
        if (hi) r[HI_W-1:0] = v[GPIO_PINS-1:BUS_W];
        else    r           = v[BUS_W-1:0];
        return r;
    endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    localparam int LAST = STAGES;

    logic [W-1:0] chain [LAST+1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k <= LAST; k++) chain[k] <= '0;
        end else begin
            chain[0] <= d_i;
            for (int k = 1; k <= LAST; k++) chain[k] <= chain[k-1];
        end
    end

    assign sync_o = chain[LAST-1];
    assign prev_o = chain[LAST];
endmodule

// File: rtl/gpio_evt.sv
module gpio_evt #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] cur_i,
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] trig_i,
    input  logic [N-1:0] pol_i,
    input  logic [N-1:0] hold_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] stat_o,
    output logic         irq_o
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        logic cond;
        logic st;

        always_comb begin
            if (trig_i[i])
                cond = pol_i[i] ? (cur_i[i] & ~prev_i[i]) : (~cur_i[i] & prev_i[i]);
            else
                cond = (cur_i[i] == pol_i[i]);
        end

        always_ff @(posedge clk) begin
            if (rst)            st <= 1'b0;
            else if (hold_i[i]) st <= cond | (st & ~clr_i[i]);
            else                st <= cond;
        end

        assign stat_o[i] = st;

        // R6: a held bit only falls through a clear
        a_r6_hold_sticky: assert property (@(posedge clk) disable iff (rst)
            (hold_i[i] && st && !clr_i[i]) |=> st);

        // R6: a clear with no fresh condition empties the bit
        a_r6_clear_works: assert property (@(posedge clk) disable iff (rst)
            (hold_i[i] && clr_i[i] && !cond) |=> !st);

        // R7: a pass-through edge event lasts one cycle only
        a_r7_edge_single: assert property (@(posedge clk) disable iff (rst)
            (!hold_i[i] && $past(!hold_i[i]) && trig_i[i] && st
             && $stable(trig_i[i]) && $stable(pol_i[i])) |=> !st);
    end

    always_ff @(posedge clk) begin
        if (rst) irq_o <= 1'b0;
        else     irq_o <= |(stat_o & en_i);
    end

    // R8: with every enable off the request is low next cycle
    a_r8_mask_all: assert property (@(posedge clk) disable iff (rst)
        (en_i == '0) |=> !irq_o);
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 we_i,
    input  logic [BUS_W-1:0]     wdata_i,
    input  logic [GPIO_PINS-1:0] stat_i,
    input  logic [GPIO_PINS-1:0] sync_i,
    output pin_cfg_t             cfg_o,
    output logic [GPIO_PINS-1:0] clr_o,
    output logic [BUS_W-1:0]     rdata_o
);
    reg_id_e id;
    logic    hi;

    assign id = reg_id_e'(addr_i[ADDR_W-1:2]);
    assign hi = addr_i[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_o <= '0;
        end else if (we_i) begin
            case (id)
                RID_DIR:  cfg_o.dir  <= put_half(cfg_o.dir,  wdata_i, hi);
                RID_PIN:  cfg_o.drv  <= put_half(cfg_o.drv,  wdata_i, hi);
                RID_EN:   cfg_o.en   <= put_half(cfg_o.en,   wdata_i, hi);
                RID_TRIG: cfg_o.trig <= put_half(cfg_o.trig, wdata_i, hi);
                RID_POL:  cfg_o.pol  <= put_half(cfg_o.pol,  wdata_i, hi);
                RID_HOLD: cfg_o.hold <= put_half(cfg_o.hold, wdata_i, hi);
                RID_AUX:  cfg_o.aux  <= put_half(cfg_o.aux,  wdata_i, hi);
                RID_PUSE: cfg_o.puse <= put_half(cfg_o.puse, wdata_i, hi);
                RID_PDIR: cfg_o.pdir <= put_half(cfg_o.pdir, wdata_i, hi);
                default:  ;
            endcase
        end
    end

    // write-one-to-clear strobe toward the status bits
    always_comb begin
        clr_o = '0;
        if (we_i && id == RID_STAT) clr_o = put_half('0, wdata_i, hi);
    end

    always_comb begin
        case (id)
            RID_DIR:  rdata_o = get_half(cfg_o.dir, hi);
            RID_PIN:  rdata_o = get_half((cfg_o.drv & cfg_o.dir) | (sync_i & ~cfg_o.dir), hi);
            RID_STAT: rdata_o = get_half(stat_i, hi);
            RID_EN:   rdata_o = get_half(cfg_o.en, hi);
            RID_TRIG: rdata_o = get_half(cfg_o.trig, hi);
            RID_POL:  rdata_o = get_half(cfg_o.pol, hi);
            RID_HOLD: rdata_o = get_half(cfg_o.hold, hi);
            RID_AUX:  rdata_o = get_half(cfg_o.aux, hi);
            RID_PUSE: rdata_o = get_half(cfg_o.puse, hi);
            RID_PDIR: rdata_o = get_half(cfg_o.pdir, hi);
            default:  rdata_o = '0;
        endcase
    end

    // R3: a lower-half write keeps the upper half of the enable word
    a_r3_half_isolate: assert property (@(posedge clk) disable iff (rst)
        (we_i && id == RID_EN && !hi) |=> $stable(cfg_o.en[GPIO_PINS-1:BUS_W]));
endmodule

// File: rtl/gpio_ctl.sv
module gpio_ctl
    import gpio_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [BUS_W-1:0]     bus_wdata,
    output logic [BUS_W-1:0]     bus_rdata,
    input  logic [GPIO_PINS-1:0] pin_in,
    output logic [GPIO_PINS-1:0] pin_out,
    output logic [GPIO_PINS-1:0] pin_oe,
    output logic [GPIO_PINS-1:0] pull_en,
    output logic [GPIO_PINS-1:0] pull_up,
    output logic [GPIO_PINS-1:0] aux_out,
    output logic                 irq
);
    pin_cfg_t             cfg;
    logic [GPIO_PINS-1:0] sync_v;
    logic [GPIO_PINS-1:0] prev_v;
    logic [GPIO_PINS-1:0] stat_v;
    logic [GPIO_PINS-1:0] clr_v;

    gpio_sync #(.W(GPIO_PINS), .STAGES(SYNC_DEPTH)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_i    (pin_in),
        .sync_o (sync_v),
        .prev_o (prev_v)
    );

    gpio_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr_i  (bus_addr),
        .we_i    (bus_we),
        .wdata_i (bus_wdata),
        .stat_i  (stat_v),
        .sync_i  (sync_v),
        .cfg_o   (cfg),
        .clr_o   (clr_v),
        .rdata_o (bus_rdata)
    );

    gpio_evt #(.N(GPIO_PINS)) u_evt (
        .clk    (clk),
        .rst    (rst),
        .cur_i  (sync_v),
        .prev_i (prev_v),
        .trig_i (cfg.trig),
        .pol_i  (cfg.pol),
        .hold_i (cfg.hold),
        .en_i   (cfg.en),
        .clr_i  (clr_v),
        .stat_o (stat_v),
        .irq_o  (irq)
    );

    assign pin_out = cfg.drv;
    assign pin_oe  = cfg.dir & ~cfg.puse;
    assign pull_en = cfg.puse;
    assign pull_up = cfg.pdir;
    assign aux_out = cfg.aux;

    // R12: the cycle after reset nothing is driven and no request is up
    a_r12_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && !irq && pull_en == '0));
endmodule

// File: tb/gpio_ctl_tb_top.sv
module gpio_ctl_tb_top;
    localparam logic [5:0] A_DIR  = 6'h00;
    localparam logic [5:0] A_PIN  = 6'h04;
    localparam logic [5:0] A_STAT = 6'h08;
    localparam logic [5:0] A_EN   = 6'h0C;
    localparam logic [5:0] A_TRIG = 6'h10;
    localparam logic [5:0] A_POL  = 6'h14;
    localparam logic [5:0] A_HOLD = 6'h18;
    localparam logic [5:0] A_AUX  = 6'h1C;
    localparam logic [5:0] A_PUSE = 6'h20;
    localparam logic [5:0] A_PDIR = 6'h24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [31:0] pin_in = '1;
    logic [31:0] pin_out, pin_oe, pull_en, pull_up, aux_out;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    gpio_ctl dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en),
        .pull_up(pull_up), .aux_out(aux_out), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic wr32(input logic [5:0] a, input logic [31:0] d);
        wr(a, d[15:0]);
        wr(a + 6'd2, d[31:16]);
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rd32(input logic [5:0] a, output logic [31:0] d);
        logic [15:0] lo, hi;
        rd(a, lo);
        rd(a + 6'd2, hi);
        d = {hi, lo};
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic clean();
        wr32(A_EN, 0); wr32(A_TRIG, 0); wr32(A_POL, 0); wr32(A_HOLD, 0);
        wr32(A_DIR, 0); wr32(A_PIN, 0); wr32(A_PUSE, 0); wr32(A_PDIR, 0);
        wr32(A_AUX, 0);
        pin_in = '1;
        settle();
        wr32(A_STAT, 32'hFFFF_FFFF);
        settle();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd32(A_DIR, v);  chk("R12 dir after reset", v, 0);
        rd32(A_EN, v);   chk("R12 enable after reset", v, 0);
        rd32(A_STAT, v); chk("R12 status with pins high", v, 0);
        rd32(A_PIN, v);  chk("R12 pin read", v, 32'hFFFF_FFFF);
        chk("R12 irq", {31'd0, irq}, 0);
        chk("R12 pin_oe", pin_oe, 0);
        chk("R12 pull_en", pull_en, 0);
    endtask

    task automatic t_dir_drive();
        logic [15:0] v;
        wr(A_DIR, 16'h00FF);
        wr(A_PIN, 16'h00A5);
        pin_in[15:0] = 16'h5A00;
        settle();
        chk("R1 pin_oe", pin_oe, 32'h0000_00FF);
        chk("R1 pin_out", pin_out, 32'h0000_00A5);
        rd(A_PIN, v);
        chk("R2 mixed pin read", {16'd0, v}, 32'h0000_5AA5);
        pin_in = '1;
        settle();
        @(negedge clk);
        pin_in[12] = 1'b0;
        @(negedge clk);
        rd(A_PIN, v);
        chk("R2 one edge: old value", {31'd0, v[12]}, 1);
        @(negedge clk);
        rd(A_PIN, v);
        chk("R2 two edges: new value", {31'd0, v[12]}, 0);
        clean();
    endtask

    task automatic t_halves();
        logic [31:0] v;
        wr(A_EN + 6'd2, 16'h1234);
        rd32(A_EN, v);
        chk("R3 upper half alone", v, 32'h1234_0000);
        wr(A_EN, 16'hBEEF);
        rd32(A_EN, v);
        chk("R3 lower half keeps upper", v, 32'h1234_BEEF);
        clean();
    endtask

    task automatic t_edge_rise_hold();
        logic [15:0] v;
        wr(A_TRIG, 16'h0008); wr(A_POL, 16'h0008);
        wr(A_HOLD, 16'h0008); wr(A_EN, 16'h0008);
        pin_in[3] = 1'b0;
        settle();
        rd(A_STAT, v);
        chk("R4 falling edge ignored in rise mode", {16'd0, v}, 0);
        pin_in[3] = 1'b1;
        settle();
        rd(A_STAT, v);
        chk("R4 rising edge latched", {16'd0, v}, 32'h8);
        chk("R9 irq up", {31'd0, irq}, 1);
        pin_in[3] = 1'b0;
        settle();
        rd(A_STAT, v);
        chk("R6 held after input drops", {16'd0, v}, 32'h8);
        wr(A_STAT, 16'h0000);
        rd(A_STAT, v);
        chk("R6 write zero no effect", {16'd0, v}, 32'h8);
        wr(A_STAT, 16'h0008);
        rd(A_STAT, v);
        chk("R6 write one clears", {16'd0, v}, 0);
        @(negedge clk);
        chk("R9 irq falls after clear", {31'd0, irq}, 0);
        clean();
    endtask

    task automatic t_edge_fall();
        logic [15:0] v;
        wr(A_TRIG + 6'd2, 16'h0010); wr(A_HOLD + 6'd2, 16'h0010);
        pin_in[20] = 1'b0;
        settle();
        rd(A_STAT + 6'd2, v);
        chk("R4 falling edge latched", {16'd0, v}, 32'h10);
        wr(A_STAT + 6'd2, 16'h0010);
        pin_in[20] = 1'b1;
        settle();
        rd(A_STAT + 6'd2, v);
        chk("R4 rising edge ignored in fall mode", {16'd0, v}, 0);
        clean();
    endtask

    task automatic t_level_low_through();
        logic [15:0] v;
        wr(A_EN, 16'h0020);
        pin_in[5] = 1'b0;
        settle();
        rd(A_STAT, v);
        chk("R5 active-low condition", {16'd0, v}, 32'h20);
        chk("R7 irq while low", {31'd0, irq}, 1);
        pin_in[5] = 1'b1;
        settle();
        rd(A_STAT, v);
        chk("R7 status follows live level", {16'd0, v}, 0);
        chk("R7 irq drops", {31'd0, irq}, 0);
        clean();
    endtask

    task automatic t_level_high_hold();
        logic [15:0] v;
        wr(A_POL + 6'd2, 16'h4000); wr(A_HOLD + 6'd2, 16'h4000);
        pin_in[30] = 1'b0;
        settle();
        wr(A_STAT + 6'd2, 16'h4000);
        rd(A_STAT + 6'd2, v);
        chk("R5 active-high idle when low", {16'd0, v}, 0);
        pin_in[30] = 1'b1;
        settle();
        wr(A_STAT + 6'd2, 16'h4000);
        rd(A_STAT + 6'd2, v);
        chk("R6 live condition beats clear", {16'd0, v}, 32'h4000);
        pin_in[30] = 1'b0;
        settle();
        rd(A_STAT + 6'd2, v);
        chk("R6 held after level ends", {16'd0, v}, 32'h4000);
        wr(A_STAT + 6'd2, 16'h4000);
        rd(A_STAT + 6'd2, v);
        chk("R6 cleared once level gone", {16'd0, v}, 0);
        clean();
    endtask

    task automatic t_enable_mask();
        logic [15:0] v;
        wr(A_TRIG, 16'h0008); wr(A_POL, 16'h0008); wr(A_HOLD, 16'h0008);
        pin_in[3] = 1'b0;
        settle();
        pin_in[3] = 1'b1;
        settle();
        chk("R8 masked pin gives no irq", {31'd0, irq}, 0);
        wr(A_EN, 16'h0008);
        @(negedge clk);
        chk("R9 irq one cycle after enable", {31'd0, irq}, 1);
        wr(A_EN, 16'h0000);
        @(negedge clk);
        chk("R8 irq off after disable", {31'd0, irq}, 0);
        rd(A_STAT, v);
        chk("R8 status kept when disabled", {16'd0, v}, 32'h8);
        clean();
    endtask

    task automatic t_through_pulse();
        wr(A_TRIG, 16'h0080); wr(A_POL, 16'h0080); wr(A_EN, 16'h0080);
        pin_in[7] = 1'b0;
        settle();
        bus_addr = A_STAT;
        pin_in[7] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 pulse present", {31'd0, bus_rdata[7]}, 1);
        chk("R9 irq not yet", {31'd0, irq}, 0);
        @(negedge clk);
        chk("R7 pulse gone", {31'd0, bus_rdata[7]}, 0);
        chk("R9 irq follows pulse", {31'd0, irq}, 1);
        @(negedge clk);
        chk("R9 irq pulse ends", {31'd0, irq}, 0);
        clean();
    endtask

    task automatic t_pull_aux();
        logic [31:0] v;
        wr(A_DIR, 16'h0003);
        wr(A_PUSE, 16'h0001);
        wr(A_PDIR + 6'd2, 16'h8000);
        chk("R10 pull_en", pull_en, 32'h1);
        chk("R10 pull_up upper half", pull_up, 32'h8000_0000);
        chk("R10 pulled pin not driven", pin_oe, 32'h2);
        wr32(A_AUX, 32'h1234_CAFE);
        chk("R11 aux_out", aux_out, 32'h1234_CAFE);
        rd32(A_AUX, v);
        chk("R11 aux readback", v, 32'h1234_CAFE);
        clean();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle();
        t_reset();
        t_dir_drive();
        t_halves();
        t_edge_rise_hold();
        t_edge_fall();
        t_level_low_through();
        t_level_high_hold();
        t_enable_mask();
        t_through_pulse();
        t_pull_aux();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule